// File: doc/BRIEF.md
# Integer Execution Unit with Immediate Forms

This block is the arithmetic and logic stage of a 32-bit load/store processor. Each cycle it can accept one operation: two register operands, a 5-bit shift count, a 16-bit immediate and a 4-bit operation code. It computes the answer combinationally and stores it in a result register on the rising clock edge. Register-register instructions use both operands. Immediate instructions use the first operand and the extended immediate.

The operation set covers wrapping addition and subtraction, bitwise AND/OR/XOR, logical left and right shifts by a count, and signed set-if-less-than. Each of these also has an immediate form where that applies. An upper-immediate operation puts the immediate in the top half of the word. If an OR-immediate follows it, using that result as the first operand, the pair builds any 32-bit constant. A valid flag enters with the operands and comes out one cycle later with the result.

Top module: `int_exec_unit`

## Requirements
- R1: While reset (`rst_n` low) is asserted, and at the first sample after it, `result` is zero and `out_valid` is low.
- R2: `out_valid` equals the value `in_valid` had one clock earlier.
- R3: A clock edge with `in_valid` low leaves `result` unchanged, whatever the other inputs are.
- R4: Code 0 (add) gives `src_a + src_b` and code 1 (sub) gives `src_a - src_b`, both modulo 2^32 and without any trap.
- R5: Code 2 gives `src_a & src_b`, code 3 gives `src_a | src_b` and code 4 gives `src_a ^ src_b`, bit by bit.
- R6: Code 5 gives `src_a` shifted left by `shamt`, and code 6 gives `src_a` shifted right by `shamt`. Both shifts fill vacated bits with zeros, and a count of 0 passes `src_a` through.
- R7: Code 7 gives 1 when `src_a < src_b` as signed two's complement numbers and 0 otherwise. Bits 31:1 of the result are always zero.
- R8: Code 8 (add immediate) gives `src_a` plus `imm` sign-extended to 32 bits. Code 12 (set-less-than immediate) compares `src_a` signed against the sign-extended `imm`.
- R9: Codes 9, 10 and 11 AND, OR and XOR `src_a` with `imm` zero-extended to 32 bits.
- R10: Code 13 (upper immediate) gives `imm` in bits 31:16 with bits 15:0 clear. Feeding that result as `src_a` to code 10 with a second immediate yields the 32-bit constant {first imm, second imm}.
- R11: Codes 14 and 15 are unassigned and give a result of zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operation present this cycle |
| op_sel | input | 4 | Operation code (see R4 to R11) |
| src_a | input | 32 | First register operand |
| src_b | input | 32 | Second register operand |
| shamt | input | 5 | Shift count |
| imm | input | 16 | Immediate field |
| out_valid | output | 1 | Result register holds a new answer |
| result | output | 32 | Registered result |

## Verification
Two things can happen in the same clock edge. The unit can present the answer to one operation while it captures the next, and on the cycles between operations it must hold that answer. The bench provokes both with a long random stream in which `in_valid` is high about three times in four. Operation codes, operands and immediates are random, and the inputs keep changing during idle cycles. At every sample the bench compares `result` with the model value of the most recent accepted operation and compares `out_valid` with the previous `in_valid`. A stale or overwritten value therefore shows up on the cycle where it occurs.

// File: rtl/exec_pkg.sv
package exec_pkg;
   localparam int OP_W = 4;

   typedef enum logic [OP_W-1:0] {
      OP_ADD  = 4'd0,
      OP_SUB  = 4'd1,
      OP_AND  = 4'd2,
      OP_OR   = 4'd3,
      OP_XOR  = 4'd4,
      OP_SLL  = 4'd5,
      OP_SRL  = 4'd6,
      OP_SLT  = 4'd7,
      OP_ADDI = 4'd8,
      OP_ANDI = 4'd9,
      OP_ORI  = 4'd10,
      OP_XORI = 4'd11,
      OP_SLTI = 4'd12,
      OP_LUI  = 4'd13,
      OP_RSV0 = 4'd14,
      OP_RSV1 = 4'd15
   } alu_op_e;
endpackage

// File: rtl/imm_extend.sv
module imm_extend #(
   parameter int XLEN  = 32,
   parameter int IMM_W = 16
) (
   input  logic [IMM_W-1:0] imm,
   output logic [XLEN-1:0]  imm_sext,
   output logic [XLEN-1:0]  imm_zext,
   output logic [XLEN-1:0]  imm_upper
);
   localparam int PAD_W = XLEN - IMM_W;

   generate
      if (IMM_W < 1 || IMM_W >= XLEN) begin : g_bad_width
         $error("imm_extend: IMM_W must lie between 1 and XLEN-1");
      end
   endgenerate

   assign imm_sext  = {{PAD_W{imm[IMM_W-1]}}, imm};
   assign imm_zext  = {{PAD_W{1'b0}}, imm};
   // upper form: immediate lands in the top IMM_W bits
   assign imm_upper = imm_zext << PAD_W;
endmodule

// File: rtl/arith_unit.sv
module arith_unit #(
   parameter int XLEN = 32
) (
   input  logic [XLEN-1:0] opnd_a,
   input  logic [XLEN-1:0] opnd_b,
   input  logic            do_sub,
   output logic [XLEN-1:0] sum,
   output logic            signed_lt
);
   localparam int MSB = XLEN - 1;

   generate
      if (XLEN < 2) begin : g_bad_width
         $error("arith_unit: XLEN must be at least 2");
      end
   endgenerate

   logic [XLEN-1:0] b_eff;
   logic [XLEN-1:0] carry_in;

   assign b_eff    = do_sub ? ~opnd_b : opnd_b;
   assign carry_in = {{(XLEN-1){1'b0}}, do_sub};
   assign sum      = opnd_a + b_eff + carry_in;

   // signed less-than from the shared subtractor: when signs differ the
   // negative operand is smaller, otherwise the difference sign decides
   assign signed_lt = (opnd_a[MSB] ^ opnd_b[MSB]) ? opnd_a[MSB] : sum[MSB];
endmodule

// File: rtl/shift_unit.sv
module shift_unit #(
   parameter int XLEN   = 32,
   parameter int STAGED = 1
) (
   input  logic [XLEN-1:0]         val,
   input  logic [$clog2(XLEN)-1:0] amt,
   input  logic                    go_right,
   output logic [XLEN-1:0]         res
);
   localparam int SW = $clog2(XLEN);

   generate
      if ((1 << SW) != XLEN) begin : g_bad_width
         $error("shift_unit: XLEN must be a power of two");
      end

      if (STAGED != 0) begin : g_staged
         logic [SW:0][XLEN-1:0] stg;
         assign stg[0] = val;
         for (genvar s = 0; s < SW; s++) begin : g_stage
            assign stg[s+1] = !amt[s]  ? stg[s] :
                              go_right ? (stg[s] >> (1 << s)) :
                                         (stg[s] << (1 << s));
         end
         assign res = stg[SW];
      end else begin : g_flat
         assign res = go_right ? (val >> amt) : (val << amt);
      end
   endgenerate
endmodule

// File: rtl/int_exec_unit.sv
module int_exec_unit
   import exec_pkg::*;
#(
   parameter int XLEN      = 32,
   parameter int IMM_W     = 16,
   parameter int SHIFT_STG = 1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    in_valid,
   input  logic [OP_W-1:0]         op_sel,
   input  logic [XLEN-1:0]         src_a,
   input  logic [XLEN-1:0]         src_b,
   input  logic [$clog2(XLEN)-1:0] shamt,
   input  logic [IMM_W-1:0]        imm,
   output logic                    out_valid,
   output logic [XLEN-1:0]         result
);
   localparam int SW = $clog2(XLEN);
   localparam logic [XLEN-1:0] ZERO_W = '0;

   generate
      if (XLEN < 8) begin : g_bad_xlen
         $error("int_exec_unit: XLEN too small");
      end
   endgenerate

   alu_op_e op;
   assign op = alu_op_e'(op_sel);

   logic [XLEN-1:0] imm_s, imm_z, imm_u;
   imm_extend #(.XLEN(XLEN), .IMM_W(IMM_W)) u_imm (
      .imm(imm), .imm_sext(imm_s), .imm_zext(imm_z), .imm_upper(imm_u)
   );

   // adder operand: register or sign-extended immediate
   logic            use_imm, is_sub;
   logic [XLEN-1:0] add_b, add_sum;
   logic            lt;
   assign use_imm = (op == OP_ADDI) || (op == OP_SLTI);
   assign is_sub  = (op == OP_SUB) || (op == OP_SLT) || (op == OP_SLTI);
   assign add_b   = use_imm ? imm_s : src_b;

   arith_unit #(.XLEN(XLEN)) u_arith (
      .opnd_a(src_a), .opnd_b(add_b), .do_sub(is_sub),
      .sum(add_sum), .signed_lt(lt)
   );

   logic [XLEN-1:0] shf;
   shift_unit #(.XLEN(XLEN), .STAGED(SHIFT_STG)) u_shift (
      .val(src_a), .amt(shamt), .go_right(op == OP_SRL), .res(shf)
   );

   logic [XLEN-1:0] nxt;
   always_comb begin
      unique case (op)
         OP_ADD, OP_SUB, OP_ADDI: nxt = add_sum;
         OP_AND:                  nxt = src_a & src_b;
         OP_OR:                   nxt = src_a | src_b;
         OP_XOR:                  nxt = src_a ^ src_b;
         OP_ANDI:                 nxt = src_a & imm_z;
         OP_ORI:                  nxt = src_a | imm_z;
         OP_XORI:                 nxt = src_a ^ imm_z;
         OP_SLL, OP_SRL:          nxt = shf;
         OP_SLT, OP_SLTI:         nxt = {{(XLEN-1){1'b0}}, lt};
         OP_LUI:                  nxt = imm_u;
         default:                 nxt = ZERO_W;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         result    <= '0;
         out_valid <= 1'b0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) result <= nxt;
      end
   end

   // R2: valid flag tracks input one cycle later
   a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);
   a_r2_idle_follows: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);
   // R3: no capture on idle cycles
   a_r3_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> $stable(result));
   // R7: compare results are single-bit booleans
   a_r7_slt_bool: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && (op_sel == OP_SLT || op_sel == OP_SLTI)) |=> (result[XLEN-1:1] == '0));
   // R10: upper-immediate clears the low half
   a_r10_lui_low_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && op_sel == OP_LUI) |=> (result[XLEN-IMM_W-1:0] == '0));
   // R11: unassigned codes produce zero
   a_r11_rsv_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && op_sel >= OP_RSV0) |=> (result == '0));
   // R6: zero-fill on right shifts by a nonzero count
   a_r6_srl_fill: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && op_sel == OP_SRL && shamt != '0) |=> (result[XLEN-1] == 1'b0));

   logic unused_sw;
   assign unused_sw = ^SW;
endmodule

// File: tb/int_exec_unit_test.sv
`timescale 1ns/1ps
module int_exec_unit_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [3:0]  op_sel = '0;
   logic [31:0] src_a = '0, src_b = '0;
   logic [4:0]  shamt = '0;
   logic [15:0] imm = '0;
   logic        out_valid;
   logic [31:0] result;

   int n_chk = 0, n_fail = 0;
   bit done = 0;

   int_exec_unit uut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_sel(op_sel),
      .src_a(src_a), .src_b(src_b), .shamt(shamt), .imm(imm),
      .out_valid(out_valid), .result(result)
   );

   always #10 clk = ~clk;

   function automatic logic [31:0] model(input logic [3:0] op, input logic [31:0] a,
                                         input logic [31:0] b, input logic [4:0] sh,
                                         input logic [15:0] im);
      logic [31:0] se, ze;
      se = {{16{im[15]}}, im};
      ze = {16'h0, im};
      case (op)
         4'd0:  return a + b;
         4'd1:  return a - b;
         4'd2:  return a & b;
         4'd3:  return a | b;
         4'd4:  return a ^ b;
         4'd5:  return a << sh;
         4'd6:  return a >> sh;
         4'd7:  return ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
         4'd8:  return a + se;
         4'd9:  return a & ze;
         4'd10: return a | ze;
         4'd11: return a ^ ze;
         4'd12: return ($signed(a) < $signed(se)) ? 32'd1 : 32'd0;
         4'd13: return {im, 16'h0};
         default: return 32'h0;
      endcase
   endfunction

   function automatic string tag_of(input logic [3:0] op);
      case (op)
         4'd0, 4'd1:          return "R4";
         4'd2, 4'd3, 4'd4:    return "R5";
         4'd5, 4'd6:          return "R6";
         4'd7:                return "R7";
         4'd8, 4'd12:         return "R8";
         4'd9, 4'd10, 4'd11:  return "R9";
         4'd13:               return "R10";
         default:             return "R11";
      endcase
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   // one operation, result sampled after the capturing edge
   task automatic run_op(input string tag, input logic [3:0] op, input logic [31:0] a,
                         input logic [31:0] b, input logic [4:0] sh, input logic [15:0] im,
                         input logic [31:0] exp);
      @(negedge clk);
      op_sel = op; src_a = a; src_b = b; shamt = sh; imm = im; in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      chk(tag, result, exp);
      chk({tag, " valid"}, {31'h0, out_valid}, 32'd1);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   endtask

   initial begin
      #(20 * 200000);
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      finish_run();
   end

   initial begin
      logic [31:0] exp_q, hi;
      logic        v_q;
      int seed;
      seed = 7;
      void'($urandom(seed));

      // R1: reset state
      repeat (3) @(negedge clk);
      chk("R1 result in reset", result, 32'h0);
      chk("R1 valid in reset", {31'h0, out_valid}, 32'h0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 result after reset", result, 32'h0);
      chk("R1 valid after reset", {31'h0, out_valid}, 32'h0);

      // directed corners
      run_op("R4 add wrap",  4'd0, 32'hFFFF_FFFF, 32'h1, 0, 0, 32'h0);
      run_op("R4 sub wrap",  4'd1, 32'h0, 32'h1, 0, 0, 32'hFFFF_FFFF);
      run_op("R5 xor",       4'd4, 32'hF0F0_1234, 32'h0FF0_FFFF, 0, 0, 32'hFF00_EDCB);
      run_op("R6 sll 31",    4'd5, 32'h0000_0003, 0, 5'd31, 0, 32'h8000_0000);
      run_op("R6 srl 31",    4'd6, 32'h8000_0000, 0, 5'd31, 0, 32'h1);
      run_op("R6 srl 0",     4'd6, 32'hDEAD_0001, 0, 5'd0, 0, 32'hDEAD_0001);
      run_op("R7 neg lt pos", 4'd7, 32'hFFFF_FFFF, 32'h1, 0, 0, 32'h1);
      run_op("R7 pos lt neg", 4'd7, 32'h1, 32'hFFFF_FFFF, 0, 0, 32'h0);
      run_op("R7 min lt max", 4'd7, 32'h8000_0000, 32'h7FFF_FFFF, 0, 0, 32'h1);
      run_op("R8 addi neg",  4'd8, 32'h0000_0010, 0, 0, 16'hFFF0, 32'h0);
      run_op("R8 addi zero-reg", 4'd8, 32'h0, 0, 0, 16'h0123, 32'h0000_0123);
      run_op("R8 slti",      4'd12, 32'h0, 0, 0, 16'h8000, 32'h0);
      run_op("R9 andi zext", 4'd9, 32'hFFFF_FFFF, 0, 0, 16'h8001, 32'h0000_8001);
      run_op("R9 xori zext", 4'd11, 32'hFFFF_0000, 0, 0, 16'hFFFF, 32'hFFFF_FFFF);
      run_op("R10 lui",      4'd13, 32'h1234_5678, 0, 0, 16'hDEAD, 32'hDEAD_0000);
      hi = result;
      run_op("R10 ori completes", 4'd10, hi, 0, 0, 16'hBEEF, 32'hDEAD_BEEF);
      run_op("R11 code14",   4'd14, 32'h5555_5555, 32'h1, 0, 16'h1, 32'h0);
      run_op("R11 code15",   4'd15, 32'hAAAA_AAAA, 32'h1, 0, 16'h1, 32'h0);

      // R3: idle cycles with changing inputs leave result alone
      @(negedge clk);
      op_sel = 4'd0; src_a = 32'h1111_1111; src_b = 32'h2222_2222;
      @(negedge clk);
      chk("R3 hold", result, 32'h0);
      chk("R2 idle valid", {31'h0, out_valid}, 32'h0);

      // random back-to-back stream
      exp_q = result; v_q = 1'b0;
      for (int i = 0; i < 4000; i++) begin
         logic [3:0] op;
         op       = 4'($urandom);
         src_a    = $urandom;
         src_b    = ($urandom % 4 == 0) ? src_a : $urandom;
         shamt    = 5'($urandom);
         imm      = 16'($urandom);
         op_sel   = op;
         in_valid = ($urandom % 4) != 0;
         if (in_valid) exp_q = model(op, src_a, src_b, shamt, imm);
         v_q = in_valid;
         @(negedge clk);
         chk(v_q ? tag_of(op) : "R3 random hold", result, exp_q);
         chk("R2 random valid", {31'h0, out_valid}, {31'h0, v_q});
      end
      in_valid = 1'b0;
      @(negedge clk);
      chk("R3 final hold", result, exp_q);
      finish_run();
   end
endmodule